// File: doc/BRIEF.md
# Host Write Access Sequencer

This block lets an external host processor write into an SRAM that a local engine also uses. The host request is a chip-select from another clock domain, so it first passes through a chain of synchronizer flops. A holdoff input from the local arbiter can then hold the access back. Once holdoff is low, the block drives a fixed order of strobes. The address and data buffers are turned on toward the RAM first. Next come the SRAM chip-select and a write-enable that lags it by half a clock. After that the host acknowledge is raised and the memory-side strobes are dropped. The sequence ends with a recovery period in which nothing is driven, so a later access cannot collide with this one on the bus.

All control outputs are decoded from one state register, so a synchronous reset forces them all to their inactive levels. The write-enable is the only exception, and it still follows the same rule. It is gated by a flag that a falling-edge flop sets in the middle of the chip-select cycle. A `busy` output tells the local arbiter to keep its own accesses away. It is high from the buffer-enable cycle through the last recovery cycle.

States and transitions: `ST_IDLE` goes to `ST_BUFEN` on a synchronized request with holdoff low, or to `ST_HOLD` on a request with holdoff high. `ST_HOLD` goes to `ST_BUFEN` when holdoff is seen low, or back to `ST_IDLE` if the request is withdrawn. `ST_BUFEN` always goes to `ST_MEMCS`, and `ST_MEMCS` always goes to `ST_ACK`. `ST_ACK` stays put while the synchronized request is still present, and goes to `ST_RECOV` when the request is released. `ST_RECOV` returns to `ST_IDLE` after `RECOV_CYCLES` cycles.

Top module: `hwr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, every active-low output (`addr_buf_en_n`, `data_buf_en_n`, `sram_cs_n`, `sram_we_n`, `host_ack_n`) is high after that edge. `buf_dir` is 0, meaning toward the host, and `busy` is 0.
- R2: Let `host_cs_n` be low at rising edge n, with holdoff low. The buffer enables are then low after edge n+2 and not before, because the request passes two synchronizer flops.
- R3: While holdoff is high with a request pending, the buffer enables stay high and `busy` stays 0. The buffers are enabled after the first edge at which holdoff is sampled low.
- R4: The buffer-enable cycle lasts exactly one clock. In it both buffer enables are low, `buf_dir` is 1 (toward the RAM), `busy` is 1, and `sram_cs_n` is still high.
- R5: The next cycle is the memory cycle. `sram_cs_n` is low and the buffer enables stay low. `sram_we_n` is high in the first half of this cycle and low in the second half, and it is high again no later than `sram_cs_n`.
- R6: In the cycle after the memory cycle, `host_ack_n` goes low. In the same cycle the buffer enables and `sram_cs_n` return high and `buf_dir` returns to 0.
- R7: `host_ack_n` stays low until the synchronized `host_cs_n` is seen high. During that time holdoff has no effect.
- R8: After the acknowledge is released, exactly one recovery cycle follows (`RECOV_CYCLES` = 1). In it all strobes are inactive and `busy` is 1. The block then returns to idle with `busy` at 0.
- R9: A new access needs `host_cs_n` to be seen high and then low again. If the host lowers it again right after release, the next buffer-enable cycle begins two cycles after the recovery cycle.
- R10: With no request pending, holdoff has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs_n | input | 1 | Host chip-select, asynchronous, active low |
| holdoff | input | 1 | Arbiter hold request; while high, a pending access is held before it starts |
| addr_buf_en_n | output | 1 | External address buffer enable, active low |
| data_buf_en_n | output | 1 | External data buffer enable, active low |
| buf_dir | output | 1 | Data buffer direction: 1 toward RAM, 0 toward host |
| sram_cs_n | output | 1 | SRAM chip-select, active low |
| sram_we_n | output | 1 | SRAM write-enable, active low, lags chip-select by half a cycle |
| host_ack_n | output | 1 | Host acknowledge, active low |
| busy | output | 1 | Tells the local engine to keep off the memory bus |

## Verification
The hardest case to reach from the ports is a release and re-assertion of host chip-select that lasts only one cycle. The synchronizer then shows a request gap of just one cycle. The state machine has to leave the acknowledge state, recover, and restart without losing or merging the two accesses. The bench reaches this case by driving `host_cs_n` high for one cycle in the first acknowledge cycle and low again right after. It then checks the full strobe trace of both accesses, cycle by cycle. The second hard point is the half-cycle write strobe: every cycle is sampled twice, once before and once after the falling edge.

// File: rtl/hwr_pkg.sv
`timescale 1ns/1ps
package hwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_BUFEN = 3'd2,
        ST_MEMCS = 3'd3,
        ST_ACK   = 3'd4,
        ST_RECOV = 3'd5
    } hwr_state_e;
endpackage

// File: rtl/hwr_sync.sv
`timescale 1ns/1ps
module hwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic req
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= ~async_n;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign req = chain[STAGES-1];
endmodule

// File: rtl/hwr_fsm.sv
`timescale 1ns/1ps
module hwr_fsm
    import hwr_pkg::*;
#(
    parameter int RECOV_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       holdoff,
    output hwr_state_e state
);
    localparam int CW = (RECOV_CYCLES > 1) ? $clog2(RECOV_CYCLES) : 1;
    localparam logic [CW-1:0] RLAST = CW'(RECOV_CYCLES - 1);

    hwr_state_e      nxt;
    logic [CW-1:0]   rcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rcnt  <= '0;
        end else begin
            state <= nxt;
            rcnt  <= (state == ST_RECOV && nxt == ST_RECOV) ? rcnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req) nxt = holdoff ? ST_HOLD : ST_BUFEN;
            ST_HOLD: begin
                if (!req)          nxt = ST_IDLE;
                else if (!holdoff) nxt = ST_BUFEN;
            end
            ST_BUFEN: nxt = ST_MEMCS;
            ST_MEMCS: nxt = ST_ACK;
            ST_ACK:   if (!req) nxt = ST_RECOV;
            ST_RECOV: if (rcnt == RLAST) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // R3
    hold_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_IDLE, ST_HOLD}) && holdoff |=> state != ST_BUFEN);
    // R7
    ack_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) && req |=> state == ST_ACK);
    // R8
    recov_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RECOV) |-> $past(state == ST_ACK));
endmodule

// File: rtl/hwr_strobe.sv
`timescale 1ns/1ps
module hwr_strobe
    import hwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  hwr_state_e state,
    output logic       addr_buf_en_n,
    output logic       data_buf_en_n,
    output logic       buf_dir,
    output logic       sram_cs_n,
    output logic       sram_we_n,
    output logic       host_ack_n,
    output logic       busy
);
    logic we_half;

    always_ff @(negedge clk) begin
        if (!rst_n) we_half <= 1'b0;
        else        we_half <= (state == ST_MEMCS);
    end

    always_comb begin
        addr_buf_en_n = 1'b1;
        data_buf_en_n = 1'b1;
        buf_dir       = 1'b0;
        sram_cs_n     = 1'b1;
        sram_we_n     = 1'b1;
        host_ack_n    = 1'b1;
        busy          = 1'b0;
        unique case (state)
            ST_IDLE, ST_HOLD: ;
            ST_BUFEN: begin
                addr_buf_en_n = 1'b0;
                data_buf_en_n = 1'b0;
                buf_dir       = 1'b1;
                busy          = 1'b1;
            end
            ST_MEMCS: begin
                addr_buf_en_n = 1'b0;
                data_buf_en_n = 1'b0;
                buf_dir       = 1'b1;
                sram_cs_n     = 1'b0;
                sram_we_n     = ~we_half;
                busy          = 1'b1;
            end
            ST_ACK: begin
                host_ack_n = 1'b0;
                busy       = 1'b1;
            end
            ST_RECOV: busy = 1'b1;
            default: ;
        endcase
    end

    // R5
    we_inside_cs_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_cs_n);
    // R5
    we_released_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n && sram_cs_n);
endmodule

// File: rtl/hwr_seq.sv
`timescale 1ns/1ps
module hwr_seq
    import hwr_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int RECOV_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_cs_n,
    input  logic holdoff,
    output logic addr_buf_en_n,
    output logic data_buf_en_n,
    output logic buf_dir,
    output logic sram_cs_n,
    output logic sram_we_n,
    output logic host_ack_n,
    output logic busy
);
    logic       req;
    hwr_state_e state;

    hwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (host_cs_n),
        .req     (req)
    );

    hwr_fsm #(.RECOV_CYCLES(RECOV_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .holdoff (holdoff),
        .state   (state)
    );

    hwr_strobe u_strobe (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .addr_buf_en_n (addr_buf_en_n),
        .data_buf_en_n (data_buf_en_n),
        .buf_dir       (buf_dir),
        .sram_cs_n     (sram_cs_n),
        .sram_we_n     (sram_we_n),
        .host_ack_n    (host_ack_n),
        .busy          (busy)
    );

    // R2
    start_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_buf_en_n) |-> $past(req));
    // R4
    buffers_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_cs_n) |-> $past(!addr_buf_en_n && !data_buf_en_n && buf_dir));
    // R6
    ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ack_n) |-> $past(!sram_cs_n) && sram_cs_n && addr_buf_en_n);
    // R8
    recovery_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack_n) |-> busy && addr_buf_en_n && sram_cs_n);
endmodule

// File: tb/sim_hwr_seq.sv
`timescale 1ns/1ps
module sim_hwr_seq;
    // word: {we_early, busy, ack_n, we_late, cs_n, dir, den_n, aen_n}
    localparam logic [7:0] W_IDLE = 8'hBB;
    localparam logic [7:0] W_BUF  = 8'hFC;
    localparam logic [7:0] W_MEM  = 8'hE4;
    localparam logic [7:0] W_ACK  = 8'hDB;
    localparam logic [7:0] W_REC  = 8'hFB;

    typedef struct { logic [7:0] v; string tag; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cs_n = 1'b1;
    logic holdoff = 1'b0;
    logic aen_n, den_n, dir, cs_n, we_n, ack_n, busy;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    hwr_seq u0 (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .holdoff(holdoff),
        .addr_buf_en_n(aen_n), .data_buf_en_n(den_n), .buf_dir(dir),
        .sram_cs_n(cs_n), .sram_we_n(we_n), .host_ack_n(ack_n), .busy(busy)
    );

    // monitor: early sample at +2, late write-enable sample at +6
    initial begin
        forever begin
            logic [7:0] got;
            @(posedge clk);
            #2;
            got = {we_n, busy, ack_n, 1'b1, cs_n, dir, den_n, aen_n};
            #4;
            got[4] = we_n;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (got !== e.v) begin
                    fails++;
                    $display("FAIL %s: outputs got %h expected %h at %0t", e.tag, got, e.v, $time);
                end
            end
        end
    end

    task automatic cyc(input logic [7:0] v, input string tag,
                       input logic cs_next, input logic hold_next);
        exp_t e;
        @(posedge clk);
        #1;
        e.v = v; e.tag = tag;
        q.push_back(e);
        #4;
        host_cs_n = cs_next;
        holdoff   = hold_next;
    endtask

    task automatic access(input int h, input int a, input bit hold_late);
        cyc(W_IDLE, "R2", 1'b0, 1'b0);
        cyc(W_IDLE, "R2", 1'b0, 1'b0);
        cyc(W_IDLE, "R2", 1'b0, h > 0);
        for (int j = 0; j < h; j++) cyc(W_IDLE, "R3", 1'b0, j < h - 1);
        cyc(W_BUF, "R4", 1'b0, hold_late);
        cyc(W_MEM, "R5", 1'b0, hold_late);
        for (int t = 0; t < a; t++) cyc(W_ACK, t == 0 ? "R6" : "R7", t == a - 1, hold_late);
        cyc(W_ACK, "R7", 1'b1, hold_late);
        cyc(W_ACK, "R7", 1'b1, 1'b0);
        cyc(W_REC, "R8", 1'b1, 1'b0);
        cyc(W_IDLE, "R8", 1'b1, 1'b0);
    endtask

    initial begin
        // R1 reset state
        cyc(W_IDLE, "R1", 1'b1, 1'b0);
        cyc(W_IDLE, "R1", 1'b1, 1'b0);
        rst_n = 1'b1;
        cyc(W_IDLE, "R1", 1'b1, 1'b0);
        // basic access, no holdoff
        access(0, 1, 1'b0);
        // R3 holdoff delays start
        access(3, 2, 1'b0);
        // R10 holdoff with no request
        cyc(W_IDLE, "R10", 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) cyc(W_IDLE, "R10", 1'b1, k < 3);
        // R7 holdoff ignored once started, long ack
        access(0, 5, 1'b1);
        // R9 back-to-back: one-cycle release during ack
        cyc(W_IDLE, "R9", 1'b0, 1'b0);
        cyc(W_IDLE, "R9", 1'b0, 1'b0);
        cyc(W_IDLE, "R9", 1'b0, 1'b0);
        cyc(W_BUF,  "R9", 1'b0, 1'b0);
        cyc(W_MEM,  "R9", 1'b0, 1'b0);
        cyc(W_ACK,  "R9", 1'b1, 1'b0);
        cyc(W_ACK,  "R9", 1'b0, 1'b0);
        cyc(W_ACK,  "R9", 1'b0, 1'b0);
        cyc(W_REC,  "R9", 1'b0, 1'b0);
        cyc(W_IDLE, "R9", 1'b0, 1'b0);
        cyc(W_BUF,  "R9", 1'b0, 1'b0);
        cyc(W_MEM,  "R9", 1'b0, 1'b0);
        cyc(W_ACK,  "R9", 1'b1, 1'b0);
        cyc(W_ACK,  "R9", 1'b1, 1'b0);
        cyc(W_ACK,  "R9", 1'b1, 1'b0);
        cyc(W_REC,  "R9", 1'b1, 1'b0);
        cyc(W_IDLE, "R9", 1'b1, 1'b0);
        cyc(W_IDLE, "R9", 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run got hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule